// File: doc/BRIEF.md
# PWM Apply and Reconfiguration Sequencer

This block takes one requested PWM setting at a time (enable, output inversion, period in clock cycles, high time in clock cycles) and turns it into an ordered series of single-cycle writes on the register port of an up-counting auto-reload timer. The timer reloads on overflow and raises its output there, and it drops the output when the count equals the match value. The sequencer works out the reload and match values from the period and the high time. It clamps the high time into a legal range and rejects periods that are too short. It also sets the order of stop, inversion change, reload/match update, counter preset and start, so that the timer never runs with a half-applied setting.

The sequencer keeps its own copy of the timer state: whether it is running, the current inversion, and the last period/high-time pair that was applied. It uses that copy to choose which steps a request needs. A request is taken only while the block is idle. When the last write has gone out, the block gives a one-cycle completion pulse, and the error flag is valid during that pulse.

Top module: `pwm_apply_seq`

## Requirements
- R1: When the timer is running and a request arrives with enable low, exactly one write goes out: select 0 (control) with bit 0 (start) clear, bit 1 holding the current inversion and bit 2 (PWM mode) set. The sequence then completes without an error.
- R2: When the requested inversion differs from the current one, the timer is first stopped if it is running (control write, start clear, old inversion). Next comes a control write with the new inversion in bit 1, start clear and bit 2 set. If the timer had been running, a counter preset and a start write follow.
- R3: A period below 2 cycles ends the request with the error flag set, and no load (select 1) or match (select 2) write is issued for it.
- R4: A high time of 0 is used as 1, and a high time of at least the period is used as period minus 1.
- R5: Load is written as 2^W minus the period, and match as load plus the clamped high time minus 1, in that order: select 1 and then select 2 in the next cycle.
- R6: When period and high time equal the last applied pair, neither a load nor a match write is issued.
- R7: When the timer is stopped and enable is requested, three writes follow one another: a control write with the requested inversion, start clear and bit 2 set; then a preset of the counter (select 3) to 2^W minus 2; then a control write with start set.
- R8: `done` is high for exactly one cycle, in the cycle after the final write (or two cycles after acceptance when no write is needed). `err` is high only together with `done`.
- R9: `req_valid` has no effect while `busy` is high. No extra writes and no extra completion come from it.
- R10: After reset the block is idle with no write and no completion pending, the timer is taken as stopped with inversion 0, and the applied pair is 0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_enable | input | 1 | Requested run state |
| req_invert | input | 1 | Requested output inversion |
| req_period | input | CW | Period in timer clock cycles |
| req_duty | input | CW | High time in timer clock cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with done |
| tmr_wr_en | output | 1 | Timer register write strobe |
| tmr_wr_sel | output | 2 | Register select: 0 control, 1 load, 2 match, 3 counter |
| tmr_wr_data | output | CW | Timer register write data |

## Verification
The requests are ordered so that each one starts from a different held state: stopped or running, inversion equal to or different from the request, and a pair that is new or already applied. The bench therefore compares the full write list against expected lists that differ in length and order. High times of 0, of exactly the period and above the period separate the two clamp directions from the pass-through case. Periods of 0, 1 and 2 mark the rejection boundary. A rejected request that also flips inversion while running shows that the stop, preset and restart still go out before the error is reported. One directed case pulses a second request mid-sequence to confirm that it is dropped.

// File: rtl/pwm_seq_pkg.sv
// Package: shared state encoding, register selects and control-word
// bit positions for the PWM apply sequencer.
package pwm_seq_pkg;

    // Sequencer steps; each write step drives one timer register write.
    typedef enum logic [3:0] {
        S_IDLE, S_EVAL, S_STOP, S_POL_STOP, S_POL_SET, S_POL_CNT,
        S_POL_START, S_LOAD, S_MATCH, S_EN_CTRL, S_EN_CNT, S_EN_START,
        S_DONE
    } seq_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_LOAD  = 2'd1;
    localparam logic [1:0] SEL_MATCH = 2'd2;
    localparam logic [1:0] SEL_CNT   = 2'd3;

    localparam int CB_START = 0;
    localparam int CB_INV   = 1;
    localparam int CB_PWM   = 2;

endpackage

// File: rtl/pwm_seq_calc.sv
// Module: pwm_seq_calc
// Purpose: turns a period and a high time (cycles) into reload and match
//          values for an up-counter that wraps at all-ones, after clamping
//          the high time to 1..period-1.
// Assumes: purely combinational; 'bad' flags a period below 2, and the
//          load/match outputs are meaningless in that case.
module pwm_seq_calc #(
    parameter int CW = 32
) (
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    output logic          bad,
    output logic [CW-1:0] load,
    output logic [CW-1:0] match
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] duty_c;

    // Clamp the high time and form reload/match values.
    always_comb begin
        bad = (period < TWO);
        if (duty == '0)
            duty_c = ONE;
        else if (duty >= period)
            duty_c = period - ONE;
        else
            duty_c = duty;
        load  = '0 - period;
        match = load + duty_c - ONE;
    end
endmodule

// File: rtl/pwm_seq_wrenc.sv
// Module: pwm_seq_wrenc
// Purpose: maps the current sequencer step onto the timer write port
//          (strobe, register select, data).
// Assumes: CW >= 3 so the control bits fit; the step value is registered.
module pwm_seq_wrenc
    import pwm_seq_pkg::*;
#(
    parameter int CW = 32
) (
    input  seq_state_e    state,
    input  logic          cur_inv,
    input  logic          new_inv,
    input  logic [CW-1:0] load,
    input  logic [CW-1:0] match,
    output logic          wr_en,
    output logic [1:0]    wr_sel,
    output logic [CW-1:0] wr_data
);
    localparam logic [CW-1:0] PRESET = {CW{1'b1}} - CW'(1);

    // Build a control word with PWM mode always on.
    function automatic logic [CW-1:0] ctrl_word(input logic start, input logic inv);
        logic [CW-1:0] w;
        w = '0;
        w[CB_START] = start;
        w[CB_INV]   = inv;
        w[CB_PWM]   = 1'b1;
        return w;
    endfunction

    // Decode the step into one register write.
    always_comb begin
        wr_en   = 1'b1;
        wr_sel  = SEL_CTRL;
        wr_data = '0;
        unique case (state)
            S_STOP, S_POL_STOP:     wr_data = ctrl_word(1'b0, cur_inv);
            S_POL_SET:              wr_data = ctrl_word(1'b0, new_inv);
            S_EN_CTRL:              wr_data = ctrl_word(1'b0, cur_inv);
            S_POL_START, S_EN_START: wr_data = ctrl_word(1'b1, cur_inv);
            S_POL_CNT, S_EN_CNT: begin
                wr_sel  = SEL_CNT;
                wr_data = PRESET;
            end
            S_LOAD: begin
                wr_sel  = SEL_LOAD;
                wr_data = load;
            end
            S_MATCH: begin
                wr_sel  = SEL_MATCH;
                wr_data = match;
            end
            default: wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_apply_seq.sv
// Module: pwm_apply_seq
// Purpose: accepts one PWM request while idle and issues the ordered
//          timer writes (stop, inversion change, reload/match, preset,
//          start), ending with a one-cycle done pulse and error flag.
// Assumes: it is the only writer of the timer, so its shadow of the run
//          state, inversion and applied pair tracks the timer exactly.
module pwm_apply_seq
    import pwm_seq_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_enable,
    input  logic          req_invert,
    input  logic [CW-1:0] req_period,
    input  logic [CW-1:0] req_duty,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          tmr_wr_en,
    output logic [1:0]    tmr_wr_sel,
    output logic [CW-1:0] tmr_wr_data
);
    localparam logic [CW-1:0] PRESET = {CW{1'b1}} - CW'(1);

    seq_state_e    state, nxt;
    logic          rq_en, rq_inv, was_run, run_q, pol_q, err_q, err_set;
    logic [CW-1:0] rq_per, rq_duty, app_per, app_duty;
    logic          bad;
    logic [CW-1:0] load, match;
    seq_state_e    en_next, cfg_next;

    pwm_seq_calc #(.CW(CW)) calc_i (
        .period(rq_per), .duty(rq_duty), .bad(bad), .load(load), .match(match)
    );

    pwm_seq_wrenc #(.CW(CW)) wrenc_i (
        .state(state), .cur_inv(pol_q), .new_inv(rq_inv), .load(load),
        .match(match), .wr_en(tmr_wr_en), .wr_sel(tmr_wr_sel),
        .wr_data(tmr_wr_data)
    );

    // Choose the step that follows the reload/match stage and the start stage.
    always_comb begin
        en_next  = (rq_en && !was_run) ? S_EN_CTRL : S_DONE;
        if (bad)
            cfg_next = S_DONE;
        else if (rq_per == app_per && rq_duty == app_duty)
            cfg_next = en_next;
        else
            cfg_next = S_LOAD;
    end

    // Next-state decision and error capture for the step sequence.
    always_comb begin
        nxt     = state;
        err_set = 1'b0;
        unique case (state)
            S_IDLE:      if (req_valid) nxt = S_EVAL;
            S_EVAL: begin
                if (run_q && !rq_en)
                    nxt = S_STOP;
                else if (rq_inv != pol_q)
                    nxt = run_q ? S_POL_STOP : S_POL_SET;
                else begin
                    nxt     = cfg_next;
                    err_set = bad;
                end
            end
            S_STOP:      nxt = S_DONE;
            S_POL_STOP:  nxt = S_POL_SET;
            S_POL_SET: begin
                if (was_run)
                    nxt = S_POL_CNT;
                else begin
                    nxt     = cfg_next;
                    err_set = bad;
                end
            end
            S_POL_CNT:   nxt = S_POL_START;
            S_POL_START: begin
                nxt     = cfg_next;
                err_set = bad;
            end
            S_LOAD:      nxt = S_MATCH;
            S_MATCH:     nxt = en_next;
            S_EN_CTRL:   nxt = S_EN_CNT;
            S_EN_CNT:    nxt = S_EN_START;
            S_EN_START:  nxt = S_DONE;
            default:     nxt = S_IDLE;
        endcase
    end

    // State register, request latch and timer shadow updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            rq_en    <= 1'b0;
            rq_inv   <= 1'b0;
            rq_per   <= '0;
            rq_duty  <= '0;
            was_run  <= 1'b0;
            run_q    <= 1'b0;
            pol_q    <= 1'b0;
            err_q    <= 1'b0;
            app_per  <= '0;
            app_duty <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                rq_en   <= req_enable;
                rq_inv  <= req_invert;
                rq_per  <= req_period;
                rq_duty <= req_duty;
                was_run <= run_q;
                err_q   <= 1'b0;
            end
            if (err_set) err_q <= 1'b1;
            if (state == S_STOP || state == S_POL_STOP) run_q <= 1'b0;
            if (state == S_POL_START || state == S_EN_START) run_q <= 1'b1;
            if (state == S_POL_SET) pol_q <= rq_inv;
            if (state == S_MATCH) begin
                app_per  <= rq_per;
                app_duty <= rq_duty;
            end
        end
    end

    // Status outputs.
    always_comb begin
        busy = (state != S_IDLE);
        done = (state == S_DONE);
        err  = done && err_q;
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r1_stop_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP) |=> (done && !err));
    a_r3_no_match_before_err: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(tmr_wr_en && tmr_wr_sel == SEL_MATCH));
    a_r5_match_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr_en && tmr_wr_sel == SEL_MATCH) |->
        $past(tmr_wr_en && tmr_wr_sel == SEL_LOAD));
    a_r7_start_after_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr_en && tmr_wr_sel == SEL_CTRL && tmr_wr_data[CB_START]) |->
        $past(tmr_wr_en && tmr_wr_sel == SEL_CNT && tmr_wr_data == PRESET));
    a_r4_match_window: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr_en && tmr_wr_sel == SEL_MATCH) |->
        (match >= load && match != {CW{1'b1}}));
    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(rq_per) && $stable(rq_duty) && $stable(rq_en)));
endmodule

// File: tb/pwm_apply_seq_tb_top.sv
module pwm_apply_seq_tb_top;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_enable = 1'b0, req_invert = 1'b0;
    logic [CW-1:0] req_period = '0, req_duty = '0;
    logic          busy, done, err, tmr_wr_en;
    logic [1:0]    tmr_wr_sel;
    logic [CW-1:0] tmr_wr_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm_apply_seq #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_enable(req_enable), .req_invert(req_invert),
        .req_period(req_period), .req_duty(req_duty), .busy(busy),
        .done(done), .err(err), .tmr_wr_en(tmr_wr_en),
        .tmr_wr_sel(tmr_wr_sel), .tmr_wr_data(tmr_wr_data)
    );

    // {en, inv, period, duty, expected write count, expected error}
    localparam logic [70:0] VEC [12] = '{
        {1'b1, 1'b0, 32'd10, 32'd4,  4'd5, 1'b0},
        {1'b1, 1'b0, 32'd10, 32'd4,  4'd0, 1'b0},
        {1'b1, 1'b0, 32'd10, 32'd0,  4'd2, 1'b0},
        {1'b1, 1'b0, 32'd8,  32'd20, 4'd2, 1'b0},
        {1'b1, 1'b1, 32'd8,  32'd20, 4'd4, 1'b0},
        {1'b1, 1'b1, 32'd1,  32'd0,  4'd0, 1'b1},
        {1'b0, 1'b1, 32'd50, 32'd25, 4'd1, 1'b0},
        {1'b0, 1'b0, 32'd50, 32'd25, 4'd3, 1'b0},
        {1'b1, 1'b0, 32'd50, 32'd25, 4'd3, 1'b0},
        {1'b1, 1'b1, 32'd0,  32'd3,  4'd4, 1'b1},
        {1'b0, 1'b1, 32'd0,  32'd3,  4'd1, 1'b0},
        {1'b0, 1'b1, 32'd1,  32'd1,  4'd0, 1'b1}
    };

    // Requirement-level model of the timer state.
    logic          m_run, m_pol;
    logic [CW-1:0] m_per, m_duty;
    logic [1:0]    e_sel [16];
    logic [CW-1:0] e_dat [16];
    int            e_n;
    logic          e_err;
    logic [1:0]    g_sel [16];
    logic [CW-1:0] g_dat [16];
    int            g_n;
    logic          g_err, g_done;

    function automatic logic [CW-1:0] cw(input logic start, input logic inv);
        return CW'(4) | (CW'(inv) << 1) | CW'(start);
    endfunction

    task automatic push(input logic [1:0] s, input logic [CW-1:0] d);
        e_sel[e_n] = s; e_dat[e_n] = d; e_n++;
    endtask

    task automatic model_reset();
        m_run = 0; m_pol = 0; m_per = '0; m_duty = '0;
    endtask

    task automatic model_req(input logic en, input logic inv,
                             input logic [CW-1:0] per, input logic [CW-1:0] duty);
        logic was;
        logic [CW-1:0] dc, ld;
        e_n = 0; e_err = 0; was = m_run;
        if (m_run && !en) begin
            push(2'd0, cw(0, m_pol)); m_run = 0;
            return;
        end
        if (inv != m_pol) begin
            if (m_run) begin push(2'd0, cw(0, m_pol)); m_run = 0; end
            push(2'd0, cw(0, inv)); m_pol = inv;
            if (was) begin
                push(2'd3, 32'hFFFF_FFFE); push(2'd0, cw(1, m_pol)); m_run = 1;
            end
        end
        if (per < 2) begin e_err = 1; return; end
        if (!(per == m_per && duty == m_duty)) begin
            dc = (duty == 0) ? 1 : (duty >= per) ? per - 1 : duty;
            ld = 32'hFFFF_FFFF - per + 1;
            push(2'd1, ld); push(2'd2, ld + dc - 1);
            m_per = per; m_duty = duty;
        end
        if (en && !was) begin
            push(2'd0, cw(0, m_pol)); push(2'd3, 32'hFFFF_FFFE);
            push(2'd0, cw(1, m_pol)); m_run = 1;
        end
    endtask

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Issue one request and log writes until done; optional mid-sequence poke.
    task automatic run_req(input logic en, input logic inv, input logic [CW-1:0] per,
                           input logic [CW-1:0] duty, input logic poke);
        @(negedge clk);
        req_enable = en; req_invert = inv; req_period = per; req_duty = duty;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        g_n = 0; g_done = 0; g_err = 0;
        for (int i = 0; i < 40 && !g_done; i++) begin
            if (poke && i == 1) begin
                req_valid = 1; req_enable = 0; req_invert = ~inv; req_period = 32'd99;
            end
            if (poke && i == 2) req_valid = 0;
            if (tmr_wr_en && g_n < 16) begin
                g_sel[g_n] = tmr_wr_sel; g_dat[g_n] = tmr_wr_data; g_n++;
            end
            if (done) begin g_done = 1; g_err = err; end
            else @(negedge clk);
        end
    endtask

    task automatic compare(input string tag, input int tab_n, input logic tab_err);
        check("R8", g_done, "completion seen", CW'(g_done), 1);
        check(tag, g_n == tab_n && g_n == e_n, "write count", CW'(g_n), CW'(tab_n));
        check("R3", g_err == tab_err && g_err == e_err, "error flag", CW'(g_err), CW'(tab_err));
        for (int k = 0; k < e_n && k < g_n; k++) begin
            check(tag, g_sel[k] == e_sel[k], "write select", CW'(g_sel[k]), CW'(e_sel[k]));
            check(tag, g_dat[k] == e_dat[k], "write data", g_dat[k], e_dat[k]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        string tags [12] = '{"R7", "R6", "R4", "R4", "R2", "R3",
                             "R1", "R2", "R7", "R2", "R1", "R3"};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: idle after reset
        check("R10", !busy && !done && !err && !tmr_wr_en, "reset outputs",
              CW'({busy, done, err, tmr_wr_en}), 0);
        model_reset();

        // Table walk: R1..R8 across held states.
        for (int v = 0; v < 12; v++) begin
            logic [70:0] t;
            t = VEC[v];
            model_req(t[70], t[69], t[68:37], t[36:5]);
            run_req(t[70], t[69], t[68:37], t[36:5], 1'b0);
            compare(tags[v], int'(t[4:1]), t[0]);
            @(negedge clk);
            check("R8", !done, "done width", CW'(done), 0);
        end

        // R10 again after reset mid-run, then R9 busy poke with period 2 boundary (R5).
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R10", !busy && !tmr_wr_en, "reset outputs", CW'({busy, tmr_wr_en}), 0);
        model_reset();
        model_req(1'b1, 1'b0, 32'd2, 32'd1);
        run_req(1'b1, 1'b0, 32'd2, 32'd1, 1'b1);
        compare("R5", 5, 1'b0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R9", !tmr_wr_en && !done && !busy, "ignored request",
                  CW'({tmr_wr_en, done, busy}), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule